// File: doc/BRIEF.md
# Asynchronous PSRAM access controller

This block sits between a synchronous request port and an asynchronous pseudo-static RAM of 512K words by 16 bits. A requester presents a one-cycle valid pulse with a direction flag, a 19-bit word address, 16 bits of write data and a two-bit byte mask. The controller turns that request into one timed memory cycle. It raises the device select, waits one setup cycle, then holds the read or write strobe for a fixed number of clock cycles. It releases the strobe and returns a one-cycle completion pulse. On a read the returned word comes with that pulse.

The strobe length comes from two parameters: the clock period in picoseconds and the speed grade (0 for a 55 ns part, 1 for a 70 ns part). The length is the access time divided by the period, rounded up. The memory is selected only while the active-low select is low and the active-high select is high. Between accesses both selects return to the idle state, so the device can drop into standby. A request whose byte mask is zero would look like a deselected cycle to the device. The controller completes such a request at once and leaves the memory pins alone.

Top module: `psram_ctrl`

## Requirements
- R1: After reset the memory pins are idle: mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_lb_n=1, mem_ub_n=1. The controller outputs busy=0, done=0 and rd_data=0.
- R2: A read request (req_write=0) with a nonzero mask selects the memory with mem_ce1_n=0 and mem_ce2=1, keeping mem_ce1_n equal to the inverse of mem_ce2 at all times. It holds mem_we_n high and mem_oe_n low for the strobe length. It asserts done in the first cycle after mem_oe_n rises, with rd_data holding the word sampled on the last strobe cycle.
- R3: A write request (req_write=1) with a nonzero mask holds mem_we_n low for the strobe length, with mem_oe_n high throughout. The controller drives the write data onto mem_dq while mem_we_n is low. mem_oe_n and mem_we_n are never low together.
- R4: During a strobe, mem_lb_n equals the inverse of mask bit 0 and gates data bits 7:0, while mem_ub_n equals the inverse of mask bit 1 and gates bits 15:8. A write changes only the enabled bytes. On a read, a disabled byte returns as zero in rd_data.
- R5: A request with mask 2'b00 produces done on the second clock edge after acceptance. The select, strobe and lane pins stay idle throughout, and memory contents are unchanged.
- R6: The strobe length is the access time (55000 ps for grade 0, 70000 ps for grade 1) divided by CLK_PERIOD_PS and rounded up. For the defaults of grade 0 and 4000 ps, that is 14 cycles.
- R7: busy is high from the cycle after acceptance through the done cycle. A req_valid seen while busy is high is ignored and causes no memory access.
- R8: mem_addr, mem_lb_n and mem_ub_n stay constant on every cycle of a strobe.
- R9: Between two strobes there is at least one cycle with both mem_oe_n and mem_we_n high, and at least one cycle with the memory deselected. mem_oe_n falls only after a cycle in which mem_we_n was high and the write data was released.
- R10: done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| mem_ce1_n | output | 1 | Active-low device select |
| mem_ce2 | output | 1 | Active-high device select |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable (write strobe) |
| mem_lb_n | output | 1 | Active-low enable for data bits 7:0 |
| mem_ub_n | output | 1 | Active-low enable for data bits 15:8 |
| mem_addr | output | 19 | Memory address bus |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
The assertions assume that a requester samples busy before pulsing req_valid. They also assume the memory drives mem_dq only while mem_oe_n is low and mem_we_n is high, so that the only bus driver is the one the strobes select. The stimulus raises req_valid only in cycles where busy reads low, with one deliberate exception that holds req_valid through a busy read to show that it is ignored. The memory model answers only inside a read strobe and only on the lanes that are enabled. All addresses stay within the model's low 256 words, so each readback compares against a known shadow value.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_SKIP   = 3'd4
   } psram_state_e;

   localparam int unsigned GRADE_FAST_PS = 55000;
   localparam int unsigned GRADE_SLOW_PS = 70000;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned grade_ps(input int unsigned grade);
      return (grade == 0) ? GRADE_FAST_PS : GRADE_SLOW_PS;
   endfunction

   function automatic int unsigned strobe_cycles(input int unsigned grade, input int unsigned clk_ps);
      return ceil_div(grade_ps(grade), clk_ps);
   endfunction

endpackage

// File: rtl/psram_strobe_timer.sv
module psram_strobe_timer
   import psram_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 4000,
   parameter int unsigned SPEED_GRADE   = 0,
   localparam int unsigned FAST_CYC = ceil_div(GRADE_FAST_PS, CLK_PERIOD_PS),
   localparam int unsigned SLOW_CYC = ceil_div(GRADE_SLOW_PS, CLK_PERIOD_PS),
   localparam int unsigned CNT_W    = $clog2(SLOW_CYC + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);

   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("psram_strobe_timer: CLK_PERIOD_PS must be nonzero");
   end
   if (SPEED_GRADE > 1) begin : g_bad_grade
      $error("psram_strobe_timer: SPEED_GRADE must be 0 or 1");
   end

   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_q;

   if (SPEED_GRADE == 0) begin : g_fast
      assign reload = CNT_W'(FAST_CYC - 1);
   end else begin : g_slow
      assign reload = CNT_W'(SLOW_CYC - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= reload;
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = run && (cnt_q == '0);

   // R6: the countdown never leaves the loaded range
   assert_timer_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= reload);

endmodule

// File: rtl/psram_sequencer.sv
module psram_sequencer
   import psram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_mask_nz,
   input  logic timer_last,
   output logic accept,
   output logic tmr_load,
   output logic tmr_run,
   output logic capture,
   output logic busy,
   output logic done,
   output logic ce_active,
   output logic oe_active,
   output logic we_active
);

   psram_state_e state_q, state_d;
   logic         wr_q;

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_valid) state_d = req_mask_nz ? ST_SETUP : ST_SKIP;
         ST_SETUP:  state_d = ST_STROBE;
         ST_STROBE: if (timer_last) state_d = ST_HOLD;
         ST_HOLD:   state_d = ST_IDLE;
         ST_SKIP:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) wr_q <= req_write;
      end
   end

   assign tmr_load  = (state_q == ST_SETUP);
   assign tmr_run   = (state_q == ST_STROBE);
   assign capture   = tmr_run && timer_last && !wr_q;
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_HOLD) || (state_q == ST_SKIP);
   assign ce_active = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
   assign oe_active = tmr_run && !wr_q;
   assign we_active = tmr_run && wr_q;

   // R10: completion lasts one cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion is reported while still busy
   assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R7: a request seen while busy does not restart the sequence
   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

// File: rtl/psram_datapath.sv
module psram_datapath #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2,
   localparam int unsigned LANE_W = DATA_W / LANES
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   input  logic              capture,
   input  logic              lanes_on,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  lane_n,
   output logic [DATA_W-1:0] rd_data
);

   if (LANES == 0 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("psram_datapath: DATA_W must split evenly into LANES");
   end

   logic [LANES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g] = lanes_on ? !mask_q[g] : 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data[g*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rd_data[g*LANE_W +: LANE_W] <= mask_q[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
         end
      end
   end

   // R8: latched request fields do not move while lanes are enabled
   assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lanes_on && $past(lanes_on)) |-> ($stable(addr_q) && $stable(mask_q)));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
   import psram_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 4000,
   parameter int unsigned SPEED_GRADE   = 0,
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned DATA_W        = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_mask,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int unsigned LANES      = 2;
   localparam int unsigned STROBE_CYC = strobe_cycles(SPEED_GRADE, CLK_PERIOD_PS);
   localparam int unsigned LEN_W      = $clog2(STROBE_CYC + 2);

   if (DATA_W % LANES != 0) begin : g_bad_width
      $error("psram_ctrl: DATA_W must be even");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("psram_ctrl: strobe must last at least one cycle");
   end

   logic accept, tmr_load, tmr_run, tmr_last, capture;
   logic ce_active, oe_active, we_active;
   logic [LANES-1:0]  lane_n;
   logic [DATA_W-1:0] wdata_q;

   psram_sequencer i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_mask_nz (|req_mask),
      .timer_last  (tmr_last),
      .accept      (accept),
      .tmr_load    (tmr_load),
      .tmr_run     (tmr_run),
      .capture     (capture),
      .busy        (busy),
      .done        (done),
      .ce_active   (ce_active),
      .oe_active   (oe_active),
      .we_active   (we_active)
   );

   psram_strobe_timer #(
      .CLK_PERIOD_PS (CLK_PERIOD_PS),
      .SPEED_GRADE   (SPEED_GRADE)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .run   (tmr_run),
      .last  (tmr_last)
   );

   psram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) i_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .capture   (capture),
      .lanes_on  (ce_active),
      .bus_in    (mem_dq),
      .addr_q    (addr_q_w),
      .wdata_q   (wdata_q),
      .lane_n    (lane_n),
      .rd_data   (rd_data)
   );

   logic [ADDR_W-1:0] addr_q_w;

   assign mem_ce1_n = !ce_active;
   assign mem_ce2   = ce_active;
   assign mem_oe_n  = !oe_active;
   assign mem_we_n  = !we_active;
   assign mem_lb_n  = lane_n[0];
   assign mem_ub_n  = lane_n[1];
   assign mem_addr  = addr_q_w;
   assign mem_dq    = we_active ? wdata_q : 'z;

   // strobe length monitor for the width check
   logic [LEN_W-1:0] strobe_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    strobe_len <= '0;
      else if (!mem_oe_n || !mem_we_n) strobe_len <= strobe_len + 1'b1;
      else                           strobe_len <= '0;
   end

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_oe_n) || $rose(mem_we_n)) |-> (strobe_len == LEN_W'(STROBE_CYC)));

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((!mem_oe_n || !mem_we_n) && $past(!mem_oe_n || !mem_we_n))
      |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

   assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_oe_n) || $rose(mem_we_n)) |=> (mem_oe_n && mem_we_n));

   assert_oe_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(mem_we_n));

   assert_deselect_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (mem_ce1_n && !mem_ce2));

   assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_mask == 2'b00) |=> (done && mem_ce1_n && mem_oe_n && mem_we_n));

   assert_select_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce1_n != mem_ce2);

endmodule

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;

   localparam int unsigned EXP_STROBE = 14; // R6: ceil(55000/4000)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        busy, done;
   logic [15:0] rd_data;
   logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
   logic [18:0] mem_addr;
   wire  [15:0] mem_dq;

   always #2 clk = ~clk;

   psram_ctrl i_psram_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
      .req_wdata (req_wdata), .req_mask (req_mask),
      .busy (busy), .done (done), .rd_data (rd_data),
      .mem_ce1_n (mem_ce1_n), .mem_ce2 (mem_ce2), .mem_oe_n (mem_oe_n),
      .mem_we_n (mem_we_n), .mem_lb_n (mem_lb_n), .mem_ub_n (mem_ub_n),
      .mem_addr (mem_addr), .mem_dq (mem_dq)
   );

   // memory model
   logic [15:0] model [0:255];
   logic [15:0] shadow [0:255];
   logic        sel;
   assign sel = !mem_ce1_n && mem_ce2;
   assign mem_dq[7:0]  = (sel && !mem_oe_n && mem_we_n && !mem_lb_n) ? model[mem_addr[7:0]][7:0]  : 8'hzz;
   assign mem_dq[15:8] = (sel && !mem_oe_n && mem_we_n && !mem_ub_n) ? model[mem_addr[7:0]][15:8] : 8'hzz;

   always @(posedge clk) begin
      if (sel && !mem_we_n) begin
         if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
         if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dq[15:8];
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         model[i]  = {i[7:0], ~i[7:0]};
         shadow[i] = {i[7:0], ~i[7:0]};
      end
   end

   typedef struct packed {
      logic        wr;
      logic [1:0]  m;
      logic [15:0] exp;
   } item_t;

   item_t sb [$];
   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
      item_t it;
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      it.wr = wr; it.m = m; it.exp = '0;
      if (!wr) begin
         if (m[0]) it.exp[7:0]  = shadow[a[7:0]][7:0];
         if (m[1]) it.exp[15:8] = shadow[a[7:0]][15:8];
      end else begin
         if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
         if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
      end
      sb.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy, "R7 busy after accept", 32'(busy), 1);
   endtask

   // monitor / scoreboard
   int  oe_cnt = 0, we_cnt = 0, idle_cnt = 1;
   bit  prev_oe_n = 1, prev_we_n = 1, prev_done = 0;
   bit  ce_seen = 0, desel = 1;
   always @(negedge clk) begin
      if (rst_n) begin
         check(mem_ce1_n == !mem_ce2, "R2 select pair", 32'(mem_ce1_n), 32'(!mem_ce2));
         if (!mem_oe_n && !mem_we_n) check(0, "R3 both strobes low", 0, 1);
         if ((!mem_oe_n && prev_oe_n) || (!mem_we_n && prev_we_n)) begin
            check(idle_cnt >= 1, "R9 idle gap", idle_cnt, 1);
            check(desel, "R9 deselect between", 32'(desel), 1);
            desel = 0;
         end
         if (mem_oe_n && mem_we_n) idle_cnt++; else idle_cnt = 0;
         if (!mem_oe_n || !mem_we_n) begin
            if (sb.size() > 0) begin
               check(mem_lb_n == !sb[0].m[0], "R4 low lane", 32'(mem_lb_n), 32'(!sb[0].m[0]));
               check(mem_ub_n == !sb[0].m[1], "R4 high lane", 32'(mem_ub_n), 32'(!sb[0].m[1]));
            end
         end
         if (!mem_oe_n) oe_cnt++;
         else begin
            if (oe_cnt != 0) begin
               check(oe_cnt == EXP_STROBE, "R6 read width", oe_cnt, EXP_STROBE);
               check(done, "R2 done after read strobe", 32'(done), 1);
            end
            oe_cnt = 0;
         end
         if (!mem_we_n) we_cnt++;
         else begin
            if (we_cnt != 0) begin
               check(we_cnt == EXP_STROBE, "R6 write width", we_cnt, EXP_STROBE);
               check(done, "R3 done after write strobe", 32'(done), 1);
            end
            we_cnt = 0;
         end
         if (sel) ce_seen = 1; else desel = 1;
         if (done) begin
            check(!prev_done, "R10 done single cycle", 32'(prev_done), 0);
            if (sb.size() == 0) check(0, "R7 unexpected done", 1, 0);
            else begin
               item_t it;
               it = sb.pop_front();
               if (it.m == 2'b00) check(!ce_seen, "R5 no bus activity", 32'(ce_seen), 0);
               else check(ce_seen, "R2 device selected", 32'(ce_seen), 1);
               if (!it.wr && it.m != 2'b00)
                  check(rd_data == it.exp, "R2/R4 read data", 32'(rd_data), 32'(it.exp));
            end
            ce_seen = 0;
         end
         prev_done = done;
         prev_oe_n = mem_oe_n;
         prev_we_n = mem_we_n;
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 6'b101111,
            "R1 pins idle", 32'({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}), 32'h2f);
      check(!busy && !done && rd_data == 0, "R1 outputs idle", 32'({busy, done, rd_data}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(0, 19'h5, 16'h0, 2'b11);            // R2 plain read
      issue(1, 19'h5, 16'h1234, 2'b11);         // R3 full write
      issue(0, 19'h5, 16'h0, 2'b11);
      issue(1, 19'h6, 16'hAAEE, 2'b01);         // R4 low lane only
      issue(0, 19'h6, 16'h0, 2'b11);
      issue(1, 19'h7, 16'hC3FF, 2'b10);         // R4 high lane only
      issue(0, 19'h7, 16'h0, 2'b11);
      issue(0, 19'h5, 16'h0, 2'b01);            // R4 high byte reads zero
      issue(0, 19'h6, 16'h0, 2'b10);            // R4 low byte reads zero
      issue(1, 19'h8, 16'hDEAD, 2'b00);         // R5 zero mask write
      issue(0, 19'h8, 16'h0, 2'b00);            // R5 zero mask read
      issue(0, 19'h8, 16'h0, 2'b11);            // R5 contents unchanged

      // R7 request held while busy is ignored
      issue(0, 19'h9, 16'h0, 2'b11);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h40; req_wdata = 16'hBEEF; req_mask = 2'b11;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      issue(0, 19'h40, 16'h0, 2'b11);

      // back-to-back pattern
      for (int k = 0; k < 8; k++) issue(1, 19'(8'h20 + k), 16'(k * 16'h1111 + 3), 2'b11);
      for (int k = 0; k < 8; k++) issue(0, 19'(8'h20 + k), 16'h0, 2'(k % 3 + 1));

      while (busy || sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      finished = 1'b1;
      summary();
   end

endmodule